// File: doc/BRIEF.md
# Fuse-Programmed Product-Term AND Plane

This block is the programmable AND plane of a small sum-of-products logic device, together with its input routing and the nonvolatile-style fuse map that programs it. Ten pin inputs and eight macrocell feedback signals each enter the plane in true and inverted form. Each of 74 product-term rows is the AND of every column that its fuses connect. Seventy-two rows are delivered to eight macrocells in blocks of nine, and two more rows are the preset and reset terms that all macrocells share. A single configuration cell in the map decides whether the first and last pin inputs feed the plane or are passed on as the macrocell clock and common output enable. The same map also holds a two-bit operating mode for each macrocell.

The map is written through a one-bit serial port. While the load enable is high, one bit enters per clock, and the bit being displaced from the current map is driven out at the same time, so a load doubles as a readback. When the enable drops, the new image is checked. A legal image replaces the map. An illegal image is dropped, the old map stays, and an error flag is raised. A lock bit suppresses the readback until the map is erased.

Top module: `pal_and_plane`

## Requirements
- R1: After reset the map is in its erased state, with every fuse bit 1 (connected). All product terms, the preset term and the reset term read 0. Every mode field reads 2'b11, clk_oe_mode is 0, and cfg_err and locked are 0.
- R2: A fuse bit of 1 connects its column. Column 2s carries signal s true and column 2s+1 carries it inverted, where signals 0..9 are pin_in[0..9] and signals 10..17 are fb_in[0..7]. A row is 1 only when every connected column is 1. A row with neither column of a signal connected ignores that signal, and a row with both columns of any signal connected is always 0.
- R3: Row r occupies map bits r*36 .. r*36+35. Rows 0..71 drive pt_out[71:0], and row 9m+8 is the direction term of macrocell m. Row 72 drives preset_term and row 73 drives reset_term.
- R4: Map bit 2664 is the configuration cell, where 0 selects clock/enable use and 1 selects plain inputs. Map bits 2665+2m and 2666+2m form the mode of macrocell m, with 2'b00 meaning registered. With the cell at 0, clk_oe_mode is 1, mc_clk follows pin_in[0], mc_oe follows pin_in[9], and both of those signals act as don't-care in every row. With the cell at 1, mc_clk and mc_oe are 0.
- R5: Bits are shifted in map bit 0 first, one per clock while prog_en is high. The image is judged in the first cycle with prog_en low, and an accepted map drives the outputs from the cycle after that.
- R6: While prog_en is high, and in the judging cycle, all product terms, preset_term and reset_term are 0.
- R7: During a load, prog_dout carries old map bit k in the cycle that new bit k is shifted in.
- R8: An image that puts any macrocell in registered mode while its configuration cell is 1 is rejected. cfg_err is set and the previous map stays in force. cfg_err clears when the next load starts.
- R9: An image that connects both columns of any signal in row 72 or row 73 is rejected in the same way as R8.
- R10: An image whose bit count differs from 2681 is rejected in the same way as R8.
- R11: A lock_req pulse while idle sets locked. While locked, prog_dout stays 0. Loads are still accepted, and locked stays set until an erase.
- R12: An erase_req pulse while idle restores the erased map of R1 and clears locked and cfg_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 10 | Pin inputs |
| fb_in | input | 8 | Macrocell feedback signals |
| prog_en | input | 1 | Serial load enable |
| prog_din | input | 1 | Serial map data in |
| prog_dout | output | 1 | Displaced old map bit |
| lock_req | input | 1 | Set the readback lock |
| erase_req | input | 1 | Restore the erased map |
| pt_out | output | 72 | Macrocell product terms |
| preset_term | output | 1 | Shared preset term |
| reset_term | output | 1 | Shared reset term |
| mc_mode | output | 16 | Two-bit mode per macrocell |
| clk_oe_mode | output | 1 | Configuration cell selects clock/enable |
| mc_clk | output | 1 | Clock passed to macrocells |
| mc_oe | output | 1 | Common output enable |
| cfg_err | output | 1 | Last image was rejected |
| locked | output | 1 | Readback is locked |

## Verification
Several rules are checked by the assertions on every cycle:
- the terms stay quiet while loading;
- no registered macrocell can coexist with a plain-input configuration cell;
- clock and enable stay idle in input mode;
- the readback stays silent under lock, and the lock persists until an erase;
- a rejection never alters the mode fields.

Other behaviour can only be shown by the bench's scenarios:
- the true and inverted column wiring and the row-to-output placement;
- the don't-care masking of the two repurposed pins;
- bit-exact serial readback;
- rejection of a bad preset or reset row and of a short load.

// File: rtl/pal_array_pkg.sv
`timescale 1ns/1ps
package pal_array_pkg;
  typedef enum logic [1:0] {
    MC_REGISTERED = 2'b00,
    MC_FIXED_IN   = 2'b01,
    MC_FIXED_OUT  = 2'b10,
    MC_BIDIR      = 2'b11
  } mc_mode_e;
endpackage

// File: rtl/pal_fuse_store.sv
`timescale 1ns/1ps
module pal_fuse_store #(
  parameter int MAP_BITS = 2681,
  parameter int N_COL    = 36,
  parameter int N_SIG    = 18,
  parameter int N_PT     = 72,
  parameter int N_FB     = 8,
  parameter int CFG_IDX  = 2664,
  parameter int MODE_IDX = 2665
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                prog_en,
  input  logic                prog_din,
  input  logic                lock_req,
  input  logic                erase_req,
  output logic [MAP_BITS-1:0] map_q,
  output logic                busy_q,
  output logic                prog_dout,
  output logic                err_q,
  output logic                lock_q
);
  import pal_array_pkg::*;

  localparam int CW = $clog2(MAP_BITS + 2);
  localparam logic [CW-1:0] CNT_FULL = CW'(MAP_BITS);
  localparam logic [CW-1:0] CNT_SAT  = CW'(MAP_BITS + 1);

  logic [MAP_BITS-1:0] shadow_q, shadow_d, map_d, shift_src;
  logic [CW-1:0]       cnt_q, cnt_d;
  logic                err_d, lock_d;
  logic                start, commit, idle;
  logic [2*N_SIG-1:0]  ctl_both;
  logic [N_FB-1:0]     mc_is_reg;
  logic                bad_cfg, bad_ctl, bad_len, image_ok;

  // both columns of one signal connected on a preset or reset row
  for (genvar r = 0; r < 2; r++) begin : g_ctl_row
    for (genvar s = 0; s < N_SIG; s++) begin : g_ctl_sig
      assign ctl_both[r*N_SIG+s] = shadow_q[(N_PT+r)*N_COL + 2*s]
                                 & shadow_q[(N_PT+r)*N_COL + 2*s + 1];
    end
  end

  for (genvar m = 0; m < N_FB; m++) begin : g_mode
    assign mc_is_reg[m] = (shadow_q[MODE_IDX+2*m +: 2] == MC_REGISTERED);
  end

  always_comb begin
    start     = prog_en & ~busy_q;
    commit    = ~prog_en & busy_q;
    idle      = ~prog_en & ~busy_q;
    shift_src = busy_q ? shadow_q : map_q;

    bad_cfg  = (|mc_is_reg) & shadow_q[CFG_IDX];
    bad_ctl  = |ctl_both;
    bad_len  = (cnt_q != CNT_FULL);
    image_ok = ~(bad_cfg | bad_ctl | bad_len);

    shadow_d = {prog_din, shift_src[MAP_BITS-1:1]};

    cnt_d = cnt_q;
    if (start)                        cnt_d = CW'(1);
    else if (prog_en && cnt_q != CNT_SAT) cnt_d = cnt_q + CW'(1);

    map_d  = map_q;
    err_d  = err_q;
    lock_d = lock_q;
    if (start) err_d = 1'b0;
    if (commit) begin
      if (image_ok) map_d = shadow_q;
      else          err_d = 1'b1;
    end
    if (idle) begin
      if (erase_req) begin
        map_d  = '1;
        lock_d = 1'b0;
        err_d  = 1'b0;
      end else if (lock_req) begin
        lock_d = 1'b1;
      end
    end

    prog_dout = prog_en & ~lock_q & shift_src[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '1;
      map_q    <= '1;
      cnt_q    <= '0;
      busy_q   <= 1'b0;
      err_q    <= 1'b0;
      lock_q   <= 1'b0;
    end else begin
      busy_q <= prog_en;
      if (prog_en) begin
        shadow_q <= shadow_d;
        cnt_q    <= cnt_d;
      end
      if (commit || idle) map_q <= map_d;
      err_q  <= err_d;
      lock_q <= lock_d;
    end
  end
endmodule

// File: rtl/pal_literal_router.sv
`timescale 1ns/1ps
module pal_literal_router #(
  parameter int N_PIN = 10,
  parameter int N_FB  = 8,
  localparam int N_SIG = N_PIN + N_FB,
  localparam int N_COL = 2 * N_SIG
) (
  input  logic [N_PIN-1:0] pin_in,
  input  logic [N_FB-1:0]  fb_in,
  input  logic             clk_oe_mode,
  output logic [N_COL-1:0] lit,
  output logic             mc_clk,
  output logic             mc_oe
);
  logic [N_SIG-1:0] sig;
  assign sig = {fb_in, pin_in};

  for (genvar s = 0; s < N_SIG; s++) begin : g_lit
    if (s == 0 || s == N_PIN - 1) begin : g_shared_pin
      // repurposed pins drop out of every row in clock/enable mode
      assign lit[2*s]   = clk_oe_mode | sig[s];
      assign lit[2*s+1] = clk_oe_mode | ~sig[s];
    end else begin : g_plain
      assign lit[2*s]   = sig[s];
      assign lit[2*s+1] = ~sig[s];
    end
  end

  assign mc_clk = clk_oe_mode & pin_in[0];
  assign mc_oe  = clk_oe_mode & pin_in[N_PIN-1];
endmodule

// File: rtl/pal_term_row.sv
`timescale 1ns/1ps
module pal_term_row #(
  parameter int N_COL = 36
) (
  input  logic [N_COL-1:0] fuse_row,
  input  logic [N_COL-1:0] lit,
  input  logic             en,
  output logic             term
);
  assign term = en & (&(lit | ~fuse_row));
endmodule

// File: rtl/pal_and_plane.sv
`timescale 1ns/1ps
module pal_and_plane #(
  parameter int N_PIN       = 10,
  parameter int N_FB        = 8,
  parameter int ROWS_PER_MC = 9,
  localparam int N_SIG    = N_PIN + N_FB,
  localparam int N_COL    = 2 * N_SIG,
  localparam int N_PT     = N_FB * ROWS_PER_MC,
  localparam int N_ROW    = N_PT + 2,
  localparam int CFG_IDX  = N_ROW * N_COL,
  localparam int MODE_IDX = CFG_IDX + 1,
  localparam int MAP_BITS = MODE_IDX + 2 * N_FB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PIN-1:0]  pin_in,
  input  logic [N_FB-1:0]   fb_in,
  input  logic              prog_en,
  input  logic              prog_din,
  output logic              prog_dout,
  input  logic              lock_req,
  input  logic              erase_req,
  output logic [N_PT-1:0]   pt_out,
  output logic              preset_term,
  output logic              reset_term,
  output logic [2*N_FB-1:0] mc_mode,
  output logic              clk_oe_mode,
  output logic              mc_clk,
  output logic              mc_oe,
  output logic              cfg_err,
  output logic              locked
);
  logic [1:0]          rst_sync_q;
  logic                rst_int_n;
  logic [MAP_BITS-1:0] map_q;
  logic                busy_q;
  logic [N_COL-1:0]    lit;
  logic [N_ROW-1:0]    row_term;
  logic                eval_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pal_fuse_store #(
    .MAP_BITS (MAP_BITS),
    .N_COL    (N_COL),
    .N_SIG    (N_SIG),
    .N_PT     (N_PT),
    .N_FB     (N_FB),
    .CFG_IDX  (CFG_IDX),
    .MODE_IDX (MODE_IDX)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .prog_en   (prog_en),
    .prog_din  (prog_din),
    .lock_req  (lock_req),
    .erase_req (erase_req),
    .map_q     (map_q),
    .busy_q    (busy_q),
    .prog_dout (prog_dout),
    .err_q     (cfg_err),
    .lock_q    (locked)
  );

  assign clk_oe_mode = ~map_q[CFG_IDX];
  assign mc_mode     = map_q[MODE_IDX +: 2*N_FB];
  assign eval_en     = ~prog_en & ~busy_q;

  pal_literal_router #(
    .N_PIN (N_PIN),
    .N_FB  (N_FB)
  ) u_router (
    .pin_in      (pin_in),
    .fb_in       (fb_in),
    .clk_oe_mode (clk_oe_mode),
    .lit         (lit),
    .mc_clk      (mc_clk),
    .mc_oe       (mc_oe)
  );

  for (genvar r = 0; r < N_ROW; r++) begin : g_row
    pal_term_row #(.N_COL(N_COL)) u_row (
      .fuse_row (map_q[r*N_COL +: N_COL]),
      .lit      (lit),
      .en       (eval_en),
      .term     (row_term[r])
    );
  end

  assign pt_out      = row_term[N_PT-1:0];
  assign preset_term = row_term[N_PT];
  assign reset_term  = row_term[N_PT+1];
endmodule

// File: rtl/pal_array_checker.sv
`timescale 1ns/1ps
module pal_array_checker #(
  parameter int N_FB = 8,
  parameter int N_PT = 72
) (
  input logic              clk,
  input logic              rst_n,
  input logic              prog_en,
  input logic              prog_dout,
  input logic              erase_req,
  input logic [N_PT-1:0]   pt_out,
  input logic              preset_term,
  input logic              reset_term,
  input logic [2*N_FB-1:0] mc_mode,
  input logic              clk_oe_mode,
  input logic              mc_clk,
  input logic              mc_oe,
  input logic              cfg_err,
  input logic              locked
);
  logic [N_FB-1:0] reg_seen;
  for (genvar m = 0; m < N_FB; m++) begin : g_reg
    assign reg_seen[m] = (mc_mode[2*m +: 2] == 2'b00);
  end

  p_quiet_while_loading_r6: assert property (@(posedge clk) disable iff (!rst_n)
    prog_en |-> (pt_out == '0 && !preset_term && !reset_term));

  p_no_readback_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !prog_dout);

  p_lock_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !erase_req) |=> locked);

  p_registered_needs_clock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|reg_seen) |-> clk_oe_mode);

  p_pins_idle_in_input_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_oe_mode |-> (!mc_clk && !mc_oe));

  p_reject_keeps_map_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> ($stable(mc_mode) && $stable(clk_oe_mode)));
endmodule

bind pal_and_plane pal_array_checker #(.N_FB(N_FB), .N_PT(N_PT)) i_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .prog_en     (prog_en),
  .prog_dout   (prog_dout),
  .erase_req   (erase_req),
  .pt_out      (pt_out),
  .preset_term (preset_term),
  .reset_term  (reset_term),
  .mc_mode     (mc_mode),
  .clk_oe_mode (clk_oe_mode),
  .mc_clk      (mc_clk),
  .mc_oe       (mc_oe),
  .cfg_err     (cfg_err),
  .locked      (locked)
);

// File: tb/test_pal_and_plane.sv
`timescale 1ns/1ps
module test_pal_and_plane;
  localparam int N_COL    = 36;
  localparam int N_PT     = 72;
  localparam int CFG_IDX  = 2664;
  localparam int MODE_IDX = 2665;
  localparam int MAP_BITS = 2681;
  localparam int N_VEC    = 7;
  // {pin_in, fb_in, expected {r0,r1,r2,r8,r9,r71,preset,reset}}
  localparam logic [25:0] VEC [N_VEC] = '{
    {10'h000, 8'h00, 8'b01000001},
    {10'h002, 8'h00, 8'b11000001},
    {10'h006, 8'h00, 8'b01000001},
    {10'h220, 8'h00, 8'b01001101},
    {10'h238, 8'h09, 8'b01010110},
    {10'h3FF, 8'hFF, 8'b01010110},
    {10'h01A, 8'h01, 8'b11010010}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [9:0] pin_in;
  logic [7:0] fb_in;
  logic prog_en, prog_din, lock_req, erase_req;
  logic prog_dout, preset_term, reset_term, clk_oe_mode, mc_clk, mc_oe, cfg_err, locked;
  logic [N_PT-1:0] pt_out;
  logic [15:0] mc_mode;

  int n_checks = 0;
  int n_fails  = 0;
  logic [MAP_BITS-1:0] map_a, map_b, map_c, map_d;

  always #10 clk = ~clk;

  pal_and_plane i_pal_and_plane (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .fb_in(fb_in),
    .prog_en(prog_en), .prog_din(prog_din), .prog_dout(prog_dout),
    .lock_req(lock_req), .erase_req(erase_req), .pt_out(pt_out),
    .preset_term(preset_term), .reset_term(reset_term), .mc_mode(mc_mode),
    .clk_oe_mode(clk_oe_mode), .mc_clk(mc_clk), .mc_oe(mc_oe),
    .cfg_err(cfg_err), .locked(locked)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // h/l: signal index connected true / inverted, -1 for none; all others don't care
  function automatic logic [MAP_BITS-1:0] put_row(input logic [MAP_BITS-1:0] m,
      input int row, input int h, input int l);
    for (int c = 0; c < N_COL; c++) m[row*N_COL+c] = 1'b0;
    if (h >= 0) m[row*N_COL+2*h]   = 1'b1;
    if (l >= 0) m[row*N_COL+2*l+1] = 1'b1;
    return m;
  endfunction

  // rb: 0 no readback check, 1 compare against old, 2 expect all zero
  task automatic load(input logic [MAP_BITS-1:0] m, input int nbits, input int rb,
                      input logic [MAP_BITS-1:0] old, input string req, input bit chk5);
    int miss = 0;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      prog_en  = 1'b1;
      prog_din = m[i];
      #1;
      if (rb == 1 && prog_dout !== old[i]) miss++;
      if (rb == 2 && prog_dout !== 1'b0) miss++;
      if (i == 100) check(pt_out == '0 && !preset_term && !reset_term, "R6 terms quiet",
                          {54'h0, pt_out, preset_term, reset_term}, 128'h0);
    end
    if (rb != 0) check(miss == 0, req, 128'(miss), 128'h0);
    @(negedge clk);
    prog_en = 1'b0;
    #1;
    if (chk5) check(pt_out == '0, "R5 judging cycle quiet", 128'(pt_out), 128'h0);
    @(negedge clk);
    #1;
    if (chk5) check(pt_out[1] == 1'b1, "R5 new map live", 128'(pt_out[1]), 128'h1);
  endtask

  task automatic apply(input logic [9:0] p, input logic [7:0] f);
    @(negedge clk);
    pin_in = p;
    fb_in  = f;
    #1;
  endtask

  initial begin
    #3000000;
    n_fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [N_PT-1:0] exp_pt;
    rst_n = 1'b0; pin_in = '0; fb_in = '0;
    prog_en = 1'b0; prog_din = 1'b0; lock_req = 1'b0; erase_req = 1'b0;

    map_a = '1;
    map_a = put_row(map_a, 0, 1, 2);
    map_a = put_row(map_a, 1, -1, -1);
    map_a = put_row(map_a, 8, 10, -1);
    map_a = put_row(map_a, 9, 5, 13);
    map_a = put_row(map_a, 71, 9, -1);
    map_a = put_row(map_a, 72, 3, -1);
    map_a = put_row(map_a, 73, -1, 4);
    map_b = map_a;
    map_b[CFG_IDX] = 1'b0;
    map_b[MODE_IDX +: 2] = 2'b00;
    map_c = map_a;
    map_c[MODE_IDX+4 +: 2] = 2'b00;
    map_d = map_b;
    map_d[72*N_COL+6] = 1'b1;
    map_d[72*N_COL+7] = 1'b1;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    apply(10'h3FF, 8'hFF);
    // R1 reset state
    check(pt_out == '0 && !preset_term && !reset_term, "R1 terms low",
          128'(pt_out), 128'h0);
    check(mc_mode == 16'hFFFF && !clk_oe_mode, "R1 modes erased",
          {111'h0, clk_oe_mode, mc_mode}, 128'hFFFF);
    check(!cfg_err && !locked, "R1 flags clear", {cfg_err, locked}, 128'h0);

    // R7 readback of the erased map while loading map A, R5 timing
    load(map_a, MAP_BITS, 1, '1, "R7 readback erased", 1'b1);
    check(!cfg_err && !clk_oe_mode, "R5 map A accepted", {cfg_err, clk_oe_mode}, 128'h0);

    // R2 R3 truth table walk
    for (int v = 0; v < N_VEC; v++) begin
      apply(VEC[v][25:16], VEC[v][15:8]);
      exp_pt = '0;
      exp_pt[0]  = VEC[v][7];
      exp_pt[1]  = VEC[v][6];
      exp_pt[2]  = VEC[v][5];
      exp_pt[8]  = VEC[v][4];
      exp_pt[9]  = VEC[v][3];
      exp_pt[71] = VEC[v][2];
      check(pt_out == exp_pt, "R2 R3 product terms", 128'(pt_out), 128'(exp_pt));
      check(preset_term == VEC[v][1] && reset_term == VEC[v][0], "R3 preset reset rows",
            {preset_term, reset_term}, 128'(VEC[v][1:0]));
    end
    apply(10'h201, 8'h00);
    check(!mc_clk && !mc_oe, "R4 input mode pins", {mc_clk, mc_oe}, 128'h0);

    // R8 registered macrocell with input-mode cell
    load(map_c, MAP_BITS, 0, '0, "", 1'b0);
    check(cfg_err, "R8 error raised", 128'(cfg_err), 128'h1);
    check(mc_mode == 16'hFFFF, "R8 old modes kept", 128'(mc_mode), 128'hFFFF);
    apply(10'h220, 8'h00);
    check(pt_out[71] && pt_out[9], "R8 old rows kept", 128'(pt_out), 128'h1);

    // R4 clock/enable map, with readback of map A
    load(map_b, MAP_BITS, 1, map_a, "R7 readback map A", 1'b0);
    check(!cfg_err && clk_oe_mode && mc_mode[1:0] == 2'b00, "R4 map B accepted",
          {cfg_err, clk_oe_mode, mc_mode}, {2'b01, 16'hFFFC});
    apply(10'h001, 8'h00);
    check(mc_clk && !mc_oe, "R4 clock follows pin 0", {mc_clk, mc_oe}, 128'h2);
    apply(10'h200, 8'h00);
    check(!mc_clk && mc_oe, "R4 enable follows pin 9", {mc_clk, mc_oe}, 128'h1);
    apply(10'h000, 8'h00);
    check(pt_out[71], "R4 pin 9 is don't care", 128'(pt_out[71]), 128'h1);

    // R9 illegal preset row
    load(map_d, MAP_BITS, 0, '0, "", 1'b0);
    check(cfg_err && clk_oe_mode && mc_mode[1:0] == 2'b00, "R9 rejected",
          {cfg_err, clk_oe_mode, mc_mode}, {2'b11, 16'hFFFC});
    apply(10'h008, 8'h00);
    check(preset_term, "R9 preset row kept", 128'(preset_term), 128'h1);

    // R10 short image
    load(map_a, MAP_BITS - 1, 0, '0, "", 1'b0);
    check(cfg_err && clk_oe_mode, "R10 short load rejected", {cfg_err, clk_oe_mode}, 128'h3);

    // R11 lock
    @(negedge clk); lock_req = 1'b1;
    @(negedge clk); lock_req = 1'b0;
    #1;
    check(locked, "R11 lock set", 128'(locked), 128'h1);
    load(map_a, MAP_BITS, 2, '0, "R11 readback blocked", 1'b0);
    check(locked && !clk_oe_mode && !cfg_err, "R11 load accepted while locked",
          {locked, clk_oe_mode, cfg_err}, 128'h4);

    // R12 erase
    @(negedge clk); erase_req = 1'b1;
    @(negedge clk); erase_req = 1'b0;
    apply(10'h002, 8'h00);
    check(!locked && mc_mode == 16'hFFFF && !clk_oe_mode, "R12 erased state",
          {locked, clk_oe_mode, mc_mode}, 128'hFFFF);
    check(pt_out == '0 && !preset_term && !reset_term, "R12 terms low",
          128'(pt_out), 128'h0);
    load(map_a, MAP_BITS, 1, '1, "R12 readback after erase", 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule